// File: doc/BRIEF.md
# Prescaled Real-Time and Watchdog Timer

This block is a timer chain clocked from the bus clock. A prescaler divides the bus clock, and each prescaled tick advances one binary chain of stages. Three functions tap that one chain. The low stages form a counter that software can read at any time, and their wrap sets an overflow flag. One of four selectable stages gives a periodic real-time tick that sets a real-time flag. The top stage is a watchdog: if software does not service it in time, it pulses a reset output.

Software reaches the block through a small register port: a read-only counter register, a control/status register and a service register. Each flag has its own enable. Each flag is acknowledged by writing one to its own acknowledge bit. An interrupt request is raised while any enabled flag is set. A freeze input stops the whole chain in the way a stopped oscillator would. The wait-mode input does not stop the timer.

Top module: `rtwd_timer`

## Requirements
- R1: After synchronous reset the counter register reads 0, the control/status register reads 0 (flags, enables and rate all clear), and irq and wd_reset are 0.
- R2: Address 0 reads the low CNT_W chain stages, zero-extended to 8 bits. The chain advances once every PRE_DIV bus cycles, so N cycles after reset the counter reads floor(N/PRE_DIV) mod 2^CNT_W. Writes to address 0 have no effect.
- R3: The overflow flag (control/status bit 7) sets on the tick where the counter wraps from all ones to zero, first at cycle 2^CNT_W*PRE_DIV after reset.
- R4: The rate field (control/status bits 1:0, value s) selects the real-time source. The real-time flag (bit 6) sets each time the low RTI_BITS+s stages wrap, that is every 2^(RTI_BITS+s)*PRE_DIV cycles. Changing the rate raises no extra event.
- R5: Control/status layout: bit 7 overflow flag, bit 6 real-time flag, bit 5 overflow enable, bit 4 real-time enable, bits 3:2 read 0, bits 1:0 rate. Addresses 2 and 3 read 0. irq is high while (overflow flag and overflow enable) or (real-time flag and real-time enable).
- R6: Writing address 1 with bit 3 at one clears the overflow flag, and with bit 2 at one clears the real-time flag. A zero in these bits leaves the flag as it is. If a set event falls in the same cycle as the acknowledge, the flag stays set.
- R7: While freeze is high, the prescaler and the chain hold their values. wait_mode has no effect on counting.
- R8: wd_reset is a one-cycle pulse raised when all CHAIN_W stages wrap. Without service it first fires 2^CHAIN_W*PRE_DIV cycles after reset and then repeats with that period.
- R9: Writing address 2 with bit 0 at zero clears every chain stage at and above stage RTI_BITS+3. This leaves the counter and the real-time phase untouched and pushes the next watchdog pulse out. Writing it with bit 0 at one has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | Halts the prescaler and the chain while high |
| wait_mode | input | 1 | Wait-mode indicator; the timer keeps running |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 counter, 1 control/status, 2 service |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for addr (combinational) |
| irq | output | 1 | Timer interrupt request |
| wd_reset | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The hardest situations to reach are the watchdog timeouts. They sit at the top of the chain, and a service write only moves the next timeout by a multiple of the slowest real-time period. The bench uses a shortened chain, so full wraps come within about a thousand cycles. It computes the exact timeout cycle after a service from the chain value at the service cycle and checks that the earlier, unserviced deadline passes silently. The acknowledge-versus-set collision is reached by placing an acknowledge write exactly on a computed real-time event cycle.

// File: rtl/rtwd_pkg.sv
package rtwd_pkg;

    localparam int DATA_W = 8;
    localparam int RATE_W = 2;
    localparam int RATE_N = 1 << RATE_W;

    typedef enum logic [1:0] {
        REG_COUNT   = 2'd0,
        REG_CTRL    = 2'd1,
        REG_SERVICE = 2'd2,
        REG_SPARE   = 2'd3
    } reg_sel_e;

    // control/status image, bit 7 down to bit 0
    typedef struct packed {
        logic              ovf_flag;
        logic              rti_flag;
        logic              ovf_en;
        logic              rti_en;
        logic [1:0]        pad;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    localparam int BIT_OVF_ACK = 3;
    localparam int BIT_RTI_ACK = 2;
    localparam int BIT_WD_KEEP = 0;

    typedef struct packed {
        logic ovf;
        logic rti;
        logic wdog;
    } evt_t;

    // true when the low nbits of v are all ones (next tick wraps them)
    function automatic logic low_full(logic [31:0] v, int unsigned nbits);
        logic [31:0] mask;
        mask = (32'd1 << nbits) - 32'd1;
        return (v & mask) == mask;
    endfunction

endpackage

// File: rtl/rtwd_prescale.sv
module rtwd_prescale #(
    parameter int PRE_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic freeze,
    input  logic wait_mode,
    output logic tick
);
    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    generate
        if (PRE_DIV > 1) begin : g_div
            logic [PW-1:0] pc;
            always_ff @(posedge clk) begin
                if (rst)
                    pc <= '0;
                else if (!freeze)
                    pc <= (pc == PW'(PRE_DIV - 1)) ? '0 : pc + 1'b1;
            end
            assign tick = !freeze && (pc == PW'(PRE_DIV - 1));

            // R7: wait mode never stalls the prescaler
            a_r7_wait_runs: assert property (@(posedge clk) disable iff (rst)
                wait_mode && !freeze |=> pc != $past(pc));
            // R2: ticks are spaced by the division ratio
            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end else begin : g_pass
            assign tick = !freeze;
            logic unused_wait;
            assign unused_wait = wait_mode;
        end
    endgenerate

endmodule

// File: rtl/rtwd_chain.sv
module rtwd_chain #(
    parameter int CHAIN_W = 15,
    parameter int KEEP_W  = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               svc,
    output logic [CHAIN_W-1:0] chain
);
    localparam logic [CHAIN_W-1:0] KEEP_MASK = CHAIN_W'((64'd1 << KEEP_W) - 64'd1);

    logic [CHAIN_W-1:0] inc;
    assign inc = chain + CHAIN_W'(tick);

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else if (svc)
            chain <= inc & KEEP_MASK;
        else
            chain <= inc;
    end

    // R2: each tick advances the kept stages by one
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        tick |=> chain[KEEP_W-1:0] == KEEP_W'($past(chain[KEEP_W-1:0]) + 1'b1));
    // R7: no tick and no service, no change
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !tick && !svc |=> $stable(chain));
    // R9: service empties the watchdog stages
    a_r9_service: assert property (@(posedge clk) disable iff (rst)
        svc |=> chain[CHAIN_W-1:KEEP_W] == '0);

endmodule

// File: rtl/rtwd_events.sv
module rtwd_events
    import rtwd_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int RTI_BITS = 11,
    parameter int CHAIN_W  = 15
) (
    input  logic [CHAIN_W-1:0] chain,
    input  logic               tick,
    input  logic [RATE_W-1:0]  rate,
    output evt_t               evt
);
    logic [RATE_N-1:0] tap_full;

    generate
        for (genvar g = 0; g < RATE_N; g++) begin : g_tap
            assign tap_full[g] = low_full(32'(chain), RTI_BITS + g);
        end
    endgenerate

    always_comb begin
        evt.ovf  = tick && low_full(32'(chain), CNT_W);
        evt.rti  = tick && tap_full[rate];
        evt.wdog = tick && low_full(32'(chain), CHAIN_W);
    end

endmodule

// File: rtl/rtwd_regs.sv
module rtwd_regs
    import rtwd_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  evt_t              evt,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rdata,
    output logic [RATE_W-1:0] rate,
    output logic              svc,
    output logic              irq,
    output logic              wd_reset
);
    ctrl_t ctrl_q;
    logic  wr_ctrl, ack_ovf, ack_rti;

    assign wr_ctrl = wr_en && (reg_sel_e'(addr) == REG_CTRL);
    assign ack_ovf = wr_ctrl && wdata[BIT_OVF_ACK];
    assign ack_rti = wr_ctrl && wdata[BIT_RTI_ACK];
    assign svc     = wr_en && (reg_sel_e'(addr) == REG_SERVICE) && !wdata[BIT_WD_KEEP];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            wd_reset <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.ovf_en <= wdata[5];
                ctrl_q.rti_en <= wdata[4];
                ctrl_q.rate   <= wdata[RATE_W-1:0];
            end
            ctrl_q.ovf_flag <= evt.ovf || (ctrl_q.ovf_flag && !ack_ovf);
            ctrl_q.rti_flag <= evt.rti || (ctrl_q.rti_flag && !ack_rti);
            wd_reset        <= evt.wdog;
        end
    end

    assign rate = ctrl_q.rate;
    assign irq  = (ctrl_q.ovf_flag && ctrl_q.ovf_en) || (ctrl_q.rti_flag && ctrl_q.rti_en);

    always_comb begin
        case (reg_sel_e'(addr))
            REG_COUNT: rdata = DATA_W'(count);
            REG_CTRL:  rdata = ctrl_q;
            default:   rdata = '0;
        endcase
    end

    // R3: overflow flag only rises from an overflow event
    a_r3_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.ovf_flag) |-> $past(evt.ovf));
    // R4: real-time flag only rises from a real-time event
    a_r4_rti_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.rti_flag) |-> $past(evt.rti));
    // R6: flag holds until acknowledged
    a_r6_rti_sticky: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.rti_flag && !ack_rti |=> ctrl_q.rti_flag);
    // R6: acknowledge without a colliding event clears the flag
    a_r6_rti_ack: assert property (@(posedge clk) disable iff (rst)
        ack_rti && !evt.rti |=> !ctrl_q.rti_flag);
    // R8: the watchdog pulse lasts one cycle
    a_r8_wd_pulse: assert property (@(posedge clk) disable iff (rst)
        wd_reset |=> !wd_reset);

endmodule

// File: rtl/rtwd_timer.sv
module rtwd_timer
    import rtwd_pkg::*;
#(
    parameter int PRE_DIV  = 4,
    parameter int CNT_W    = 8,
    parameter int RTI_BITS = 11,
    parameter int CHAIN_W  = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       freeze,
    input  logic       wait_mode,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       wd_reset
);
    localparam int KEEP_W = RTI_BITS + RATE_N - 1;

    logic               tick;
    logic               svc;
    logic [CHAIN_W-1:0] chain;
    logic [RATE_W-1:0]  rate;
    evt_t               evt;

    rtwd_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst(rst), .freeze(freeze), .wait_mode(wait_mode), .tick(tick)
    );

    rtwd_chain #(.CHAIN_W(CHAIN_W), .KEEP_W(KEEP_W)) u_chain (
        .clk(clk), .rst(rst), .tick(tick), .svc(svc), .chain(chain)
    );

    rtwd_events #(.CNT_W(CNT_W), .RTI_BITS(RTI_BITS), .CHAIN_W(CHAIN_W)) u_evt (
        .chain(chain), .tick(tick), .rate(rate), .evt(evt)
    );

    rtwd_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .evt(evt), .count(chain[CNT_W-1:0]), .rdata(rdata), .rate(rate),
        .svc(svc), .irq(irq), .wd_reset(wd_reset)
    );

    // R1: nothing is signalled in the cycle after reset
    a_r1_quiet: assert property (@(posedge clk) rst |=> !irq && !wd_reset);

endmodule

// File: tb/rtwd_timer_test.sv
`timescale 1ns/1ps
module rtwd_timer_test;
    localparam int P  = 2;
    localparam int CW = 4;
    localparam int RB = 4;
    localparam int WW = 9;

    logic       clk = 0, rst = 1, freeze = 0, wait_mode = 0, wr_en = 0;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       irq, wd_reset;

    int  edges = 0, checks = 0, errors = 0;
    bit  done = 0;
    logic [7:0] v;

    rtwd_timer #(.PRE_DIV(P), .CNT_W(CW), .RTI_BITS(RB), .CHAIN_W(WW)) uut (
        .clk(clk), .rst(rst), .freeze(freeze), .wait_mode(wait_mode),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .wd_reset(wd_reset)
    );

    always #2 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at edge %0d: actual=%0h expected=%0h", req, edges, act, exp);
        end
    endtask

    task automatic step(int k);
        if (k <= 0) return;
        repeat (k) @(posedge clk);
        edges += k;
        @(negedge clk);
    endtask

    task automatic goto_edge(int e);
        step(e - edges);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk);
        edges++;
        @(negedge clk);
        wr_en = 0; wdata = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] r);
        addr = a;
        #0.5;
        r = rdata;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: bench hung, actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        edges = 0;

        // R1 reset state
        rd(0, v); chk("R1 counter", v, 0);
        rd(1, v); chk("R1 ctrl", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 wd_reset", wd_reset, 0);

        // R2 counter sweep through one full wrap
        for (int n = 1; n <= 31; n++) begin
            step(1);
            rd(0, v); chk("R2 counter", v, (n / P) % (1 << CW));
        end
        rd(1, v); chk("R3 ovf before wrap", v[7], 0);
        step(1);
        rd(1, v);
        chk("R3 ovf at wrap", v[7], 1);
        chk("R4 rti rate0 at 16 ticks", v[6], 1);
        chk("R5 irq masked", irq, 0);

        wr(0, 8'hAA);
        rd(0, v); chk("R2 write ignored", v, (edges / P) % (1 << CW));

        wr(1, 8'h20);
        chk("R5 irq from ovf", irq, 1);
        rd(1, v); chk("R5 layout", v, 8'hE0);
        wr(1, 8'h20);
        rd(1, v); chk("R6 zero ack keeps flags", v, 8'hE0);
        wr(1, 8'h28);
        rd(1, v); chk("R6 ovf ack", v, 8'h60);
        chk("R6 irq drops", irq, 0);
        wr(1, 8'h14);
        rd(1, v); chk("R6 rti ack", v, 8'h10);
        chk("R6 irq low", irq, 0);
        rd(2, v); chk("R5 addr2 reads 0", v, 0);
        rd(3, v); chk("R5 addr3 reads 0", v, 0);

        // R4 sweep of all four rates
        for (int s = 0; s < 4; s++) begin
            int per, e;
            per = 1 << (RB + 1 + s);
            if ((edges + 1) % 32 == 0) step(1);
            wr(1, 8'h14 | 8'(s));
            e = (edges / per + 1) * per;
            goto_edge(e - 1);
            rd(1, v); chk($sformatf("R4 rate%0d quiet", s), v[6], 0);
            chk("R5 irq quiet", irq, 0);
            step(1);
            rd(1, v); chk($sformatf("R4 rate%0d fires", s), v[6], 1);
            chk("R5 irq from rti", irq, 1);
        end

        // R6 acknowledge colliding with a set event
        begin
            int e;
            if ((edges + 1) % 32 == 0) step(1);
            wr(1, 8'h14);
            e = (edges / 32 + 1) * 32;
            goto_edge(e - 1);
            wr(1, 8'h14);
            rd(1, v); chk("R6 set wins over ack", v[6], 1);
            wr(1, 8'h14);
            rd(1, v); chk("R6 later ack clears", v[6], 0);
        end

        // R8 first watchdog timeout
        goto_edge(1023); chk("R8 before timeout", wd_reset, 0);
        step(1);         chk("R8 timeout pulse", wd_reset, 1);
        step(1);         chk("R8 one cycle", wd_reset, 0);

        // R9 service pushes the deadline out
        goto_edge(1499);
        wr(2, 8'h00);
        rd(0, v); chk("R9 counter kept", v, (1500 / P) % (1 << CW));
        goto_edge(2048); chk("R9 old deadline silent", wd_reset, 0);
        goto_edge(2303); chk("R9 before new deadline", wd_reset, 0);
        step(1);         chk("R9 new deadline", wd_reset, 1);
        goto_edge(2399);
        wr(2, 8'h01);
        goto_edge(3327); chk("R9 bit one no effect, quiet", wd_reset, 0);
        step(1);         chk("R9 bit one no effect, fires", wd_reset, 1);

        // R7 wait mode keeps running, freeze holds
        wait_mode = 1;
        step(10);
        rd(0, v); chk("R7 wait keeps counting", v, (edges / P) % (1 << CW));
        wait_mode = 0;
        begin
            logic [7:0] c0;
            freeze = 1;
            rd(0, c0);
            step(20);
            rd(0, v); chk("R7 freeze holds", v, c0);
            freeze = 0;
            step(7);
            rd(0, v); chk("R7 resume after freeze", v, ((edges - 20) / P) % (1 << CW));
        end

        done = 1;
        report();
        $finish;
    end
endmodule